// File: doc/BRIEF.md
# Signed Energy Accumulator with No-Load Gate

This block turns per-cycle power results into running energy totals. At the end of every computation cycle, an upstream stage presents two power magnitudes, one active and one reactive. Each magnitude is unsigned, in units of 0.01 W, and comes with its own direction bit. The block presents a cycle duration in milliseconds at the same time. For each quantity, the block adds the energy of that cycle, in whole milliwatt-hours, to one of two registers. The direction bit picks the register: an import register for power absorbed by the load, or an export register for power delivered by the load.

Each of the four registers keeps its own sub-milliwatt-hour remainder, and that remainder is carried into the next cycle. No energy is lost to truncation. Accumulation needs two conditions. An enable bit must be set, and the power magnitude must reach a programmable no-load threshold. A small register port reads the four totals and reads or writes the threshold and the enable bit. A clear strobe resets all totals and remainders.

Top module: `energy_accum_top`

## Requirements
- R1: After reset, all four energy registers read 0, the threshold reads 100 (1.00 W), and the enable bit reads 0.
- R2: While the enable bit (bit 0 of control, address 5) is 0, a cycle-end pulse leaves all four energy registers unchanged.
- R3: A quantity whose direction bit is 0 adds to its import register (address 0 for active, 2 for reactive). A quantity whose direction bit is 1 adds to its export register (address 1 for active, 3 for reactive). The other register of that pair does not change. Active and reactive are steered independently.
- R4: A magnitude strictly below the threshold adds nothing and leaves the remainder unchanged. A magnitude equal to the threshold is accumulated.
- R5: The increment is floor((mag*ms + rem)/360000) mWh, and the new remainder is (mag*ms + rem) mod 360000, where rem is that register's stored remainder.
- R6: A clear strobe zeroes all four registers and their remainders in one cycle. It wins over a cycle-end pulse in the same cycle, and that pulse is lost.
- R7: A write to address 4 sets the 16-bit threshold. A write to address 5 sets the enable bit from wdata bit 0. Both read back at the same addresses.
- R8: reg_rdata shows the register at the address presented one clock earlier. Addresses 6 and 7 read 0.
- R9: Without a cycle-end pulse, changes on the power and duration inputs do not alter any energy register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_done | input | 1 | End-of-computation-cycle pulse |
| cyc_ms | input | 16 | Cycle duration in ms |
| p_act_mag | input | 32 | Active power magnitude, 0.01 W units |
| p_act_neg | input | 1 | Active power direction, 1 = export |
| p_rea_mag | input | 32 | Reactive power magnitude, 0.01 W units |
| p_rea_neg | input | 1 | Reactive power direction, 1 = export |
| clr | input | 1 | Clear strobe for totals and remainders |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 64 | Registered read data |

## Verification
An energy register changes on the clock edge that samples cyc_done or clr. A register write takes effect on its own edge. reg_rdata is loaded one edge after the address is presented. The bench therefore drives every stimulus at a falling edge and lets its edge pass. It then presents the address and samples reg_rdata at the falling edge after the next rising edge. This means every result is observed two rising edges after its stimulus, never at an edge. The bench model keeps its own four totals and four remainders and applies the threshold, direction and enable rules to them.

// File: rtl/energy_pkg.sv
package energy_pkg;
  localparam int unsigned MAG_W   = 32;
  localparam int unsigned DUR_W   = 16;
  localparam int unsigned THR_W   = 16;
  localparam int unsigned E_W     = 64;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned WDATA_W = 32;
  // 0.01 W * 1 ms = 1e-5 J ; 1 mWh = 3.6 J -> 360000 units per mWh
  localparam int unsigned MWH_DIV = 360000;
  localparam int unsigned RES_W   = $clog2(MWH_DIV);
  localparam logic [THR_W-1:0] THR_RST = THR_W'(100);

  typedef enum logic [ADDR_W-1:0] {
    A_ACT_IMP = 3'd0,
    A_ACT_EXP = 3'd1,
    A_REA_IMP = 3'd2,
    A_REA_EXP = 3'd3,
    A_THRESH  = 3'd4,
    A_CTRL    = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/energy_scaler.sv
module energy_scaler #(
  parameter int unsigned MAG_W = energy_pkg::MAG_W,
  parameter int unsigned DUR_W = energy_pkg::DUR_W,
  parameter int unsigned RES_W = energy_pkg::RES_W,
  parameter int unsigned DIV   = energy_pkg::MWH_DIV,
  localparam int unsigned PROD_W = MAG_W + DUR_W + 1
) (
  input  logic [MAG_W-1:0]  mag,
  input  logic [DUR_W-1:0]  dur,
  input  logic [RES_W-1:0]  res_in,
  output logic [PROD_W-1:0] quo,
  output logic [RES_W-1:0]  res_out
);
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] rem_full;

  always_comb begin
    prod     = PROD_W'(mag) * PROD_W'(dur) + PROD_W'(res_in);
    quo      = prod / PROD_W'(DIV);
    rem_full = prod % PROD_W'(DIV);
    res_out  = rem_full[RES_W-1:0];
  end
endmodule

// File: rtl/energy_lane.sv
module energy_lane #(
  parameter int unsigned MAG_W = energy_pkg::MAG_W,
  parameter int unsigned DUR_W = energy_pkg::DUR_W,
  parameter int unsigned THR_W = energy_pkg::THR_W,
  parameter int unsigned E_W   = energy_pkg::E_W,
  parameter int unsigned RES_W = energy_pkg::RES_W,
  parameter int unsigned DIV   = energy_pkg::MWH_DIV,
  localparam int unsigned PROD_W = MAG_W + DUR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             cyc_done,
  input  logic             en,
  input  logic [THR_W-1:0] thr,
  input  logic [DUR_W-1:0] dur,
  input  logic [MAG_W-1:0] mag,
  input  logic             neg,
  output logic [E_W-1:0]   e_imp,
  output logic [E_W-1:0]   e_exp
);
  logic [E_W-1:0]    energy [2];
  logic [RES_W-1:0]  resid  [2];
  logic [RES_W-1:0]  res_sel;
  logic [PROD_W-1:0] quo;
  logic [RES_W-1:0]  res_nxt;
  logic              above;
  logic              fire;

  assign above   = MAG_W'(thr) <= mag;
  assign fire    = cyc_done && en && above;
  assign res_sel = resid[neg];

  energy_scaler #(
    .MAG_W(MAG_W), .DUR_W(DUR_W), .RES_W(RES_W), .DIV(DIV)
  ) u_scale (
    .mag(mag), .dur(dur), .res_in(res_sel), .quo(quo), .res_out(res_nxt)
  );

  for (genvar s = 0; s < 2; s++) begin : g_side
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        energy[s] <= '0;
        resid[s]  <= '0;
      end else if (fire && (neg == s[0])) begin
        energy[s] <= energy[s] + E_W'(quo);
        resid[s]  <= res_nxt;
      end
    end

    assert_residue_range_R5: assert property (@(posedge clk) disable iff (rst)
      resid[s] < RES_W'(DIV));
  end

  assign e_imp = energy[0];
  assign e_exp = energy[1];

  assert_hold_disabled_R2: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> ($stable(e_imp) && $stable(e_exp)));
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!cyc_done && !clr) |=> ($stable(e_imp) && $stable(e_exp)));
  assert_steer_exp_R3: assert property (@(posedge clk) disable iff (rst)
    (cyc_done && !clr && neg) |=> $stable(e_imp));
  assert_steer_imp_R3: assert property (@(posedge clk) disable iff (rst)
    (cyc_done && !clr && !neg) |=> $stable(e_exp));
  assert_noload_R4: assert property (@(posedge clk) disable iff (rst)
    (cyc_done && !clr && (mag < MAG_W'(thr))) |=> ($stable(e_imp) && $stable(e_exp)));
  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (e_imp == '0 && e_exp == '0));
endmodule

// File: rtl/energy_cfg.sv
module energy_cfg #(
  parameter int unsigned ADDR_W  = energy_pkg::ADDR_W,
  parameter int unsigned WDATA_W = energy_pkg::WDATA_W,
  parameter int unsigned THR_W   = energy_pkg::THR_W,
  parameter int unsigned E_W     = energy_pkg::E_W,
  parameter logic [THR_W-1:0] THR_RST = energy_pkg::THR_RST
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                we,
  input  logic [WDATA_W-1:0]  wdata,
  input  logic [3:0][E_W-1:0] totals,
  output logic [THR_W-1:0]    thr,
  output logic                en,
  output logic [E_W-1:0]      rdata
);
  import energy_pkg::*;

  logic [E_W-1:0] rd_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr <= THR_RST;
      en  <= 1'b0;
    end else if (we) begin
      if (addr == A_THRESH) thr <= wdata[THR_W-1:0];
      if (addr == A_CTRL)   en  <= wdata[0];
    end
  end

  always_comb begin
    case (addr)
      A_ACT_IMP: rd_nxt = totals[0];
      A_ACT_EXP: rd_nxt = totals[1];
      A_REA_IMP: rd_nxt = totals[2];
      A_REA_EXP: rd_nxt = totals[3];
      A_THRESH:  rd_nxt = E_W'(thr);
      A_CTRL:    rd_nxt = E_W'(en);
      default:   rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nxt;
  end

  assert_thr_write_R7: assert property (@(posedge clk) disable iff (rst)
    (we && addr == A_THRESH) |=> (thr == $past(wdata[THR_W-1:0])));
  assert_en_write_R7: assert property (@(posedge clk) disable iff (rst)
    (we && addr == A_CTRL) |=> (en == $past(wdata[0])));
  assert_unused_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (addr > A_CTRL) |=> (rdata == '0));
endmodule

// File: rtl/energy_accum_top.sv
module energy_accum_top #(
  parameter int unsigned MAG_W   = energy_pkg::MAG_W,
  parameter int unsigned DUR_W   = energy_pkg::DUR_W,
  parameter int unsigned THR_W   = energy_pkg::THR_W,
  parameter int unsigned E_W     = energy_pkg::E_W,
  parameter int unsigned ADDR_W  = energy_pkg::ADDR_W,
  parameter int unsigned WDATA_W = energy_pkg::WDATA_W,
  parameter int unsigned DIV     = energy_pkg::MWH_DIV
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cyc_done,
  input  logic [DUR_W-1:0]   cyc_ms,
  input  logic [MAG_W-1:0]   p_act_mag,
  input  logic               p_act_neg,
  input  logic [MAG_W-1:0]   p_rea_mag,
  input  logic               p_rea_neg,
  input  logic               clr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_we,
  input  logic [WDATA_W-1:0] reg_wdata,
  output logic [E_W-1:0]     reg_rdata
);
  localparam int unsigned LANES = 2;
  localparam int unsigned RES_W = $clog2(DIV);

  logic [THR_W-1:0]          thr;
  logic                      en;
  logic [LANES-1:0][MAG_W-1:0] mags;
  logic [LANES-1:0]          negs;
  logic [2*LANES-1:0][E_W-1:0] totals;

  assign mags = {p_rea_mag, p_act_mag};
  assign negs = {p_rea_neg, p_act_neg};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    energy_lane #(
      .MAG_W(MAG_W), .DUR_W(DUR_W), .THR_W(THR_W), .E_W(E_W),
      .RES_W(RES_W), .DIV(DIV)
    ) u_lane (
      .clk(clk), .rst(rst), .clr(clr), .cyc_done(cyc_done), .en(en),
      .thr(thr), .dur(cyc_ms), .mag(mags[l]), .neg(negs[l]),
      .e_imp(totals[2*l]), .e_exp(totals[2*l+1])
    );
  end

  energy_cfg #(
    .ADDR_W(ADDR_W), .WDATA_W(WDATA_W), .THR_W(THR_W), .E_W(E_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
    .totals(totals), .thr(thr), .en(en), .rdata(reg_rdata)
  );
endmodule

// File: tb/tb_energy_accum_top.sv
module tb_energy_accum_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        cyc_done = 0;
  logic [15:0] cyc_ms = 0;
  logic [31:0] p_act_mag = 0;
  logic        p_act_neg = 0;
  logic [31:0] p_rea_mag = 0;
  logic        p_rea_neg = 0;
  logic        clr = 0;
  logic [2:0]  reg_addr = 0;
  logic        reg_we = 0;
  logic [31:0] reg_wdata = 0;
  logic [63:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  longint unsigned m_e [4];
  longint unsigned m_r [4];
  int unsigned     m_thr = 100;
  bit              m_en  = 0;

  always #10 clk = ~clk;

  energy_accum_top dut (
    .clk(clk), .rst(rst), .cyc_done(cyc_done), .cyc_ms(cyc_ms),
    .p_act_mag(p_act_mag), .p_act_neg(p_act_neg),
    .p_rea_mag(p_rea_mag), .p_rea_neg(p_rea_neg), .clr(clr),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  task automatic check(string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output longint unsigned v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
    if (a == 3'd4) m_thr = d[15:0];
    if (a == 3'd5) m_en  = d[0];
  endtask

  function automatic void model_lane(int lane, longint unsigned mag, bit neg, longint unsigned ms);
    longint unsigned p;
    int idx;
    if (!m_en || mag < m_thr) return;
    idx = lane * 2 + int'(neg);
    p = mag * ms + m_r[idx];
    m_e[idx] += p / 360000;
    m_r[idx]  = p % 360000;
  endfunction

  task automatic pulse(longint unsigned am, bit an, longint unsigned rm, bit rn, longint unsigned ms, bit with_clr);
    @(negedge clk);
    p_act_mag = am[31:0]; p_act_neg = an; p_rea_mag = rm[31:0]; p_rea_neg = rn;
    cyc_ms = ms[15:0]; cyc_done = 1; clr = with_clr;
    @(negedge clk); cyc_done = 0; clr = 0;
    if (with_clr) begin
      for (int i = 0; i < 4; i++) begin m_e[i] = 0; m_r[i] = 0; end
    end else begin
      model_lane(0, am, an, ms);
      model_lane(1, rm, rn, ms);
    end
  endtask

  task automatic check_all(string req);
    longint unsigned v;
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), v);
      check(req, v, m_e[i]);
    end
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint unsigned v;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 4; i++) begin m_e[i] = 0; m_r[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 / R8: reset state
    check_all("R1");
    rd(3'd4, v); check("R1 threshold", v, 100);
    rd(3'd5, v); check("R1 enable", v, 0);
    rd(3'd6, v); check("R8 addr6", v, 0);
    rd(3'd7, v); check("R8 addr7", v, 0);

    // R2: disabled
    pulse(5_000_000, 0, 7_000_000, 1, 1000, 0);
    check_all("R2");

    // R7: config
    wr(3'd5, 32'h1);
    rd(3'd5, v); check("R7 enable", v, 1);
    wr(3'd4, 32'd250);
    rd(3'd4, v); check("R7 threshold", v, 250);

    // R4: just below / at threshold
    pulse(249, 0, 249, 1, 60000, 0);
    check_all("R4 below");
    pulse(250, 0, 250, 1, 60000, 0);
    check_all("R4 equal");

    // R3 / R5: directed steering and remainder carry
    pulse(360000, 1, 360000, 0, 1, 0);
    check_all("R3");
    pulse(100000, 0, 100000, 0, 3, 0);
    check_all("R5 carry");
    pulse(100000, 0, 100000, 0, 3, 0);
    check_all("R5 carry2");

    // R9: inputs wiggle without pulse
    @(negedge clk);
    p_act_mag = 32'hFFFF_FFFF; p_rea_mag = 32'h7FFF_0000; cyc_ms = 16'hFFFF;
    repeat (4) @(negedge clk);
    check_all("R9");

    // R6: clear beats simultaneous pulse
    pulse(9_000_000, 0, 9_000_000, 1, 5000, 1);
    check_all("R6");
    // remainder cleared too: 359999 units leaves 0 mWh if remainder was 0
    pulse(359999, 0, 359999, 1, 1, 0);
    check_all("R6 residue");

    // Random mix: R3, R4, R5
    for (int n = 0; n < 150; n++) begin
      longint unsigned am, rm, ms;
      am = (n % 5 == 0) ? longint'($urandom_range(200, 300)) : longint'($urandom);
      rm = (n % 7 == 0) ? longint'($urandom_range(200, 300)) : longint'($urandom_range(0, 50_000_000));
      ms = longint'($urandom_range(1, 65535));
      pulse(am, 1'($urandom), rm, 1'($urandom), ms, 0);
      if (n == 75) begin
        wr(3'd5, 32'h0);
        pulse(am, 0, rm, 0, ms, 0);
        check_all("R2 random");
        wr(3'd5, 32'h1);
      end
      if (n % 10 == 9) check_all("R5 random");
    end
    check_all("R3 final");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule